// File: doc/BRIEF.md
# Saturating Add/Subtract Unit with Operand Doubling

This block is a 32-bit signed arithmetic unit offering four operations: plain add, plain subtract, and two "doubled" variants in which the second operand is first multiplied by two and then combined with the first operand. Every arithmetic step clamps to the largest or smallest representable signed value instead of wrapping. In the doubled variants there are two such steps, and each one can clamp independently.

Each operation is presented with a one-cycle valid strobe. The registered result appears on the next clock edge, together with a result-valid strobe. A sticky saturation flag records that at least one clamp has happened since it was last cleared. The flag is cleared through a dedicated input. Instruction decode and operand storage belong to the surrounding pipeline.

Top module: `sat_addsub_unit`

## Requirements
- R1: Opcode 2'b00 (add) produces opA + opB, clamped on signed overflow.
- R2: Opcode 2'b01 (subtract) produces opA - opB, clamped on signed overflow.
- R3: Opcode 2'b10 (doubled add) first doubles opB with clamping, then produces opA + doubled value with clamping.
- R4: Opcode 2'b11 (doubled subtract) first doubles opB with clamping, then produces opA - doubled value with clamping. For example, opA = 0 and opB = 0x80000000 gives 0x7FFFFFFF.
- R5: Positive overflow gives 0x7FFFFFFF and negative overflow gives 0x80000000, in every stage.
- R6: The sticky flag is set when the doubling step clamps, even if the final add or subtract does not clamp.
- R7: Once set, the flag stays set through later operations that do not clamp, as long as flagClear is low.
- R8: flagClear high at a clock edge clears the flag. If an accepted operation clamps at that same edge, the flag ends up set.
- R9: result and resValid update one clock after opValid. Without opValid, resValid is low and result holds its value.
- R10: After reset, result is 0, resValid is 0 and satFlag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Accept an operation this cycle |
| opCode | input | 2 | 00 add, 01 sub, 10 doubled add, 11 doubled sub |
| opA | input | 32 | First operand (never doubled) |
| opB | input | 32 | Second operand (doubled in the doubled forms) |
| flagClear | input | 1 | Clear the sticky saturation flag |
| resValid | output | 1 | Result registered on the last edge |
| result | output | 32 | Saturated signed result |
| satFlag | output | 1 | Sticky saturation indicator |

## Verification
The only state is the result register and the sticky flag, so an internal fault shows at the ports one clock after the operation that caused it. A wrong clamp, or a wrong choice of operand to double, appears at once in result. A doubling clamp that goes unrecorded is exposed by vectors where only the first stage saturates: they show satFlag low while result is correct. A flag that is not sticky, or that is cleared with the wrong priority, shows up in the first cycle of the directed clear and sticky sequences.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DADD = 2'b10,
    OP_DSUB = 2'b11
  } sat_op_e;

  typedef struct packed {
    logic load;
    logic dbl;
    logic sub;
    logic clr;
  } sat_ctrl_t;
endpackage

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
(
  input  logic       opValid,
  input  logic [1:0] opCode,
  input  logic       flagClear,
  output sat_ctrl_t  strobes
);
  always_comb begin
    strobes      = '0;
    strobes.load = opValid;
    strobes.clr  = flagClear;
    unique case (sat_op_e'(opCode))
      OP_ADD:  begin strobes.dbl = 1'b0; strobes.sub = 1'b0; end
      OP_SUB:  begin strobes.dbl = 1'b0; strobes.sub = 1'b1; end
      OP_DADD: begin strobes.dbl = 1'b1; strobes.sub = 1'b0; end
      OP_DSUB: begin strobes.dbl = 1'b1; strobes.sub = 1'b1; end
      default: begin strobes.dbl = 1'b0; strobes.sub = 1'b0; end
    endcase
  end
endmodule

// File: rtl/sat_datapath.sv
module sat_datapath
  import sat_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  sat_ctrl_t        strobes,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             resValid,
  output logic [WIDTH-1:0] result,
  output logic             satFlag
);
  localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] MAX_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] rhsVal;
  logic             dblClamp;
  logic [WIDTH:0]   wideSum;
  logic [WIDTH-1:0] finalVal;
  logic             sumClamp;
  logic             flagNext;

  // Stage 1: optional doubling of opB with clamp
  always_comb begin
    rhsVal   = opB;
    dblClamp = 1'b0;
    if (strobes.dbl) begin
      if (opB[WIDTH-1] != opB[WIDTH-2]) begin
        dblClamp = 1'b1;
        rhsVal   = opB[WIDTH-1] ? MAX_NEG : MAX_POS;
      end else begin
        rhsVal = {opB[WIDTH-2:0], 1'b0};
      end
    end
  end

  // Stage 2: add or subtract in one extra bit, then clamp
  always_comb begin
    if (strobes.sub)
      wideSum = {opA[WIDTH-1], opA} - {rhsVal[WIDTH-1], rhsVal};
    else
      wideSum = {opA[WIDTH-1], opA} + {rhsVal[WIDTH-1], rhsVal};
    sumClamp = wideSum[WIDTH] != wideSum[WIDTH-1];
    if (sumClamp)
      finalVal = wideSum[WIDTH] ? MAX_NEG : MAX_POS;
    else
      finalVal = wideSum[WIDTH-1:0];
  end

  // Set beats clear when both happen at one edge
  always_comb begin
    flagNext = strobes.clr ? 1'b0 : satFlag;
    if (strobes.load && (dblClamp || sumClamp))
      flagNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      resValid <= 1'b0;
      satFlag  <= 1'b0;
    end else begin
      resValid <= strobes.load;
      satFlag  <= flagNext;
      if (strobes.load)
        result <= finalVal;
    end
  end
endmodule

// File: rtl/sat_addsub_unit.sv
module sat_addsub_unit
  import sat_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [1:0]       opCode,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             flagClear,
  output logic             resValid,
  output logic [WIDTH-1:0] result,
  output logic             satFlag
);
  sat_ctrl_t strobes;

  sat_ctrl u_ctrl (
    .opValid  (opValid),
    .opCode   (opCode),
    .flagClear(flagClear),
    .strobes  (strobes)
  );

  sat_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .resValid(resValid),
    .result  (result),
    .satFlag (satFlag)
  );
endmodule

// File: rtl/sat_addsub_chk.sv
module sat_addsub_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic [1:0]       opCode,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             flagClear,
  input logic             resValid,
  input logic [WIDTH-1:0] result,
  input logic             satFlag
);
  p_valid_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!resValid && $stable(result)));
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && !flagClear) |=> satFlag);
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && !opValid) |=> !satFlag);
  p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!satFlag && !opValid) |=> !satFlag);
  p_add_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 2'b00 && opA == '0) |=> (result == $past(opB)));
  p_sub_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 2'b01 && opB == '0) |=> (result == $past(opA) && !$rose(satFlag)));
endmodule

bind sat_addsub_unit sat_addsub_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
  .opA(opA), .opB(opB), .flagClear(flagClear),
  .resValid(resValid), .result(result), .satFlag(satFlag)
);

// File: tb/tb_sat_addsub_unit.sv
module tb_sat_addsub_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  // {opcode, opA, opB, expected result, expected flag}
  localparam logic [98:0] VECS [NVEC] = '{
    {2'b00, 32'h00000005, 32'h00000007, 32'h0000000C, 1'b0}, // R1
    {2'b00, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1}, // R1 R5
    {2'b00, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1}, // R1 R5
    {2'b01, 32'h0000000A, 32'h00000003, 32'h00000007, 1'b0}, // R2
    {2'b01, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1}, // R2 R5
    {2'b01, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1}, // R2 R5
    {2'b10, 32'h00000001, 32'h00000003, 32'h00000007, 1'b0}, // R3
    {2'b10, 32'h00000000, 32'h40000000, 32'h7FFFFFFF, 1'b1}, // R3 R6
    {2'b10, 32'hFFFFFFFF, 32'h40000000, 32'h7FFFFFFE, 1'b1}, // R6
    {2'b10, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1}, // R3 R5
    {2'b11, 32'h0000000A, 32'h00000002, 32'h00000006, 1'b0}, // R4
    {2'b11, 32'h00000000, 32'h80000000, 32'h7FFFFFFF, 1'b1}, // R4 corner
    {2'b11, 32'hFFFFFFFF, 32'hC0000000, 32'h7FFFFFFF, 1'b0}, // R4 no clamp
    {2'b11, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1}, // R4 R5
    {2'b00, 32'hFFFFFFFE, 32'hFFFFFFFE, 32'hFFFFFFFC, 1'b0}  // R1
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opCode = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        flagClear = 1'b0;
  logic        resValid;
  logic [31:0] result;
  logic        satFlag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_addsub_unit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .flagClear(flagClear),
    .resValid(resValid), .result(result), .satFlag(satFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, one edge, sample 1 time unit after posedge
  task automatic cycle(input logic v, input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic clr);
    @(negedge clk);
    opValid = v; opCode = op; opA = a; opB = b; flagClear = clr;
    @(posedge clk);
    #1;
    opValid = 1'b0; flagClear = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    #(CLK_PERIOD * 2 + 1);
    check("R10 result", result, 32'h0);
    check("R10 resValid", {31'b0, resValid}, 32'h0);
    check("R10 satFlag", {31'b0, satFlag}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      cycle(1'b0, 2'b00, '0, '0, 1'b1);
      cycle(1'b1, VECS[i][98:97], VECS[i][96:65], VECS[i][64:33], 1'b0);
      check($sformatf("R1-R6 vec%0d result", i), result, VECS[i][32:1]);
      check($sformatf("R6 vec%0d flag", i), {31'b0, satFlag}, {31'b0, VECS[i][0]});
      check($sformatf("R9 vec%0d valid", i), {31'b0, resValid}, 32'h1);
    end

    // R9: hold with no valid
    held = result;
    cycle(1'b0, 2'b01, 32'h12345678, 32'h1, 1'b0);
    check("R9 hold result", result, held);
    check("R9 idle resValid", {31'b0, resValid}, 32'h0);

    // R7: sticky through non-clamping ops
    cycle(1'b1, 2'b00, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0);
    cycle(1'b1, 2'b00, 32'h1, 32'h1, 1'b0);
    check("R7 result", result, 32'h2);
    check("R7 sticky", {31'b0, satFlag}, 32'h1);
    cycle(1'b1, 2'b11, 32'h5, 32'h1, 1'b0);
    check("R7 sticky2", {31'b0, satFlag}, 32'h1);

    // R8: clear alone, clear with clamp, clear with non-clamp
    cycle(1'b0, 2'b00, '0, '0, 1'b1);
    check("R8 clear", {31'b0, satFlag}, 32'h0);
    cycle(1'b1, 2'b01, 32'h80000000, 32'h7FFFFFFF, 1'b1);
    check("R8 set wins", {31'b0, satFlag}, 32'h1);
    check("R8 result", result, 32'h80000000);
    cycle(1'b1, 2'b00, 32'h3, 32'h4, 1'b1);
    check("R8 clear with op", {31'b0, satFlag}, 32'h0);
    check("R8 result2", result, 32'h7);

    // R10: reset mid-run
    @(negedge clk); rstN = 1'b0;
    #1;
    check("R10 rerst result", result, 32'h0);
    check("R10 rerst valid", {31'b0, resValid}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule